// File: doc/BRIEF.md
# SPI Burst Exchange Sequencer

This block sequences data transfers for an SPI master. Software-side logic queues 32-bit words into an internal transmit queue. The sequencer takes each word and hands it, one byte at a time and lowest byte first, to an external byte-wide shifter through a request/done handshake. Each byte the shifter returns is placed into a receive word, which goes into an internal receive queue once the word is finished.

A programmable burst length, given in bits as a field value plus one, sets how many bytes go out. A burst may span several words or end partway through one. Three things can start a transfer: an accepted push while the immediate-start mode is on, turning that mode on while words are waiting, or writing the exchange bit from 0 to 1 while the mode is off. A per-channel wave bit picks between two behaviours. In one, each burst ends with a completion flag and the engine halts. In the other, bursts run back to back until the queue is empty.

A registered decoder drives four active-low chip selects from a channel select when the selected channel is configured as master.

Top module: `spi_xfer_seq`

## Requirements
- R1: The burst length in bits is `cfg_burst_bits + 1`. It is loaded when the remaining count is zero or negative and a word is about to be fetched. A length that is not a multiple of 8 goes out rounded up to whole bytes (12 bits gives 2 bytes).
- R2: A word sends at most 4 bytes. Byte 0 (bits 7:0) goes out first, then bits 15:8, and so on. The n-th returned byte lands in bits 8n+7:8n of the receive word, and bytes not exchanged read as zero.
- R3: `byte_req` stays high with `byte_out` stable until a cycle with `byte_done` high. Each such cycle completes exactly one byte.
- R4: Each byte lowers both the per-word count and the remaining burst count by 8. A 40-bit burst sends 4 bytes of one word, then 1 byte of the next, without reloading.
- R5: One cycle after a configuration change, `cs_n` is low only at index `cfg_chan_sel` when `cfg_chan_master[cfg_chan_sel]` is 1. Otherwise `cs_n` is 4'hF. At most one chip select is ever low.
- R6: With `cfg_start_mode` = 1 on a master channel, an accepted push while idle starts a transfer. A 0-to-1 change of `cfg_start_mode` while the transmit queue holds words also starts one. A non-master channel never starts.
- R7: With `cfg_start_mode` = 0 on a master channel, an exchange-bit write of 1 starts a transfer only if the held exchange bit is 0. Writing 1 over a held 1 does nothing.
- R8: Multi-burst mode applies when the channel is master, `cfg_start_mode` = 0 and `cfg_chan_wave[cfg_chan_sel]` = 1. In this mode `xch_flag` is forced to 1 at every burst start, and bursts continue until the transmit queue is empty.
- R9: Outside multi-burst mode, `done_flag` is set when a burst ends and the engine goes idle, even if words remain queued.
- R10: When a word completes while the receive queue is full, the word is discarded and `ovf_flag` is set.
- R11: When the engine finds the transmit queue empty, it sets `done_flag` and clears `xch_flag`.
- R12: Start requests that arrive while `busy` is high are ignored. A push made then is only queued.
- R13: A push while `tx_full` is high is dropped. `clr_done` and `clr_ovf` clear their flags, and a same-cycle set wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_bits | input | 12 | Burst length minus one, in bits |
| cfg_chan_sel | input | 2 | Selected channel |
| cfg_chan_master | input | 4 | Per-channel master enable |
| cfg_chan_wave | input | 4 | Per-channel multi-burst enable |
| cfg_start_mode | input | 1 | Immediate-start mode |
| xch_wr | input | 1 | Exchange-bit write strobe |
| xch_wdata | input | 1 | Value written to the exchange bit |
| tx_push | input | 1 | Push a word into the transmit queue |
| tx_data | input | 32 | Word to push |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Pop a receive word (data valid next cycle) |
| rx_data | output | 32 | Popped receive word |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| clr_done | input | 1 | Clear the completion flag |
| clr_ovf | input | 1 | Clear the overflow flag |
| done_flag | output | 1 | Transfer complete |
| ovf_flag | output | 1 | Receive overflow |
| xch_flag | output | 1 | Held exchange bit |
| busy | output | 1 | Transfer in progress |
| byte_req | output | 1 | Byte exchange request to the shifter |
| byte_out | output | 8 | Byte to send |
| byte_done | input | 1 | Shifter finished a byte |
| byte_in | input | 8 | Byte returned by the shifter |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The first stimulus is a single full-word burst in immediate mode, which shows byte order and receive assembly. A 16-bit burst over two queued words shows that a burst stops partway with words left. Re-writing the held exchange bit then shows that only a 0-to-1 change restarts the engine. A 40-bit burst separates a burst that carries its count across words from one that reloads per word, and a 12-bit burst shows rounding to whole bytes. Multi-burst single-byte runs over a full queue, overflow of the receive queue, pushes during a run, and a non-master channel each show whether the engine starts, continues or halts correctly, with every sent byte matched against a queue of expected bytes.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES  = WORD_W / BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WORD,
    ST_FETCH,
    ST_XFER,
    ST_PUSH,
    ST_END
  } seq_state_t;
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) begin
        rd_ptr  <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
        rd_data <= mem[rd_ptr];
      end
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R13: occupancy never exceeds depth; a write into a full queue is dropped
  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  assert_full_drop_R13: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> $stable(count));
endmodule

// File: rtl/spi_seq_csdrv.sv
module spi_seq_csdrv #(
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_master,
  input  logic [SEL_W-1:0] sel,
  output logic [NCH-1:0]   cs_n
);
  logic [NCH-1:0] cs_next;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cs_next[c] = !(is_master && (sel == SEL_W'(c)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cs_n <= '1;
    else     cs_n <= cs_next;
  end

  // R5: never more than one chip select asserted
  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  burst_field,
  input  logic              is_master,
  input  logic              wave_sel,
  input  logic              start_mode,
  input  logic              tx_accept,
  input  logic              xch_wr,
  input  logic              xch_wdata,
  input  logic              clr_done,
  input  logic              clr_ovf,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_rd_data,
  input  logic              rx_full,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              tx_rd,
  output logic              rx_wr,
  output logic [WORD_W-1:0] rx_wr_data,
  output logic              byte_req,
  output logic [BYTE_W-1:0] byte_out,
  output logic              done_flag,
  output logic              ovf_flag,
  output logic              xch_flag,
  output logic              busy
);
  localparam int REM_W = LEN_W + 2;
  localparam int PER_W = $clog2(WORD_W) + 2;
  localparam int IDX_W = $clog2(BYTES);
  localparam logic signed [PER_W-1:0] PER_BYTE = PER_W'(BYTE_W);
  localparam logic signed [REM_W-1:0] REM_WORD = REM_W'(WORD_W);
  localparam logic signed [REM_W-1:0] REM_BYTE = REM_W'(BYTE_W);

  seq_state_t state;
  logic signed [REM_W-1:0] rem_q;
  logic signed [PER_W-1:0] per_q;
  logic [IDX_W-1:0]        idx_q;
  logic [WORD_W-1:0]       word_q;
  logic [WORD_W-1:0]       acc_q;
  logic                    smc_q;
  logic                    rem_nonpos, multi;
  logic                    start_push, start_smc, start_xch;

  assign rem_nonpos = rem_q[REM_W-1] || (rem_q == '0);
  assign multi      = is_master && !start_mode && wave_sel;
  assign start_push = start_mode && is_master && tx_accept;
  assign start_smc  = start_mode && !smc_q && is_master && !tx_empty;
  assign start_xch  = !start_mode && is_master && xch_wr && xch_wdata && !xch_flag;

  assign busy       = (state != ST_IDLE);
  assign byte_req   = (state == ST_XFER);
  assign byte_out   = word_q[BYTE_W-1:0];
  assign tx_rd      = (state == ST_WORD) && !tx_empty;
  assign rx_wr      = (state == ST_PUSH) && !rx_full;
  assign rx_wr_data = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rem_q     <= '0;
      per_q     <= '0;
      idx_q     <= '0;
      word_q    <= '0;
      acc_q     <= '0;
      smc_q     <= 1'b0;
      done_flag <= 1'b0;
      ovf_flag  <= 1'b0;
      xch_flag  <= 1'b0;
    end else begin
      smc_q <= start_mode;
      if (clr_done) done_flag <= 1'b0;
      if (clr_ovf)  ovf_flag  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (xch_wr) xch_flag <= xch_wdata;
          if (start_push || start_smc || start_xch) state <= ST_WORD;
        end
        ST_WORD: begin
          if (tx_empty) begin
            done_flag <= 1'b1;
            xch_flag  <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            if (rem_nonpos) begin
              rem_q <= REM_W'(burst_field) + REM_W'(1);
              if (multi) xch_flag <= 1'b1;
            end
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          word_q <= tx_rd_data;
          acc_q  <= '0;
          idx_q  <= '0;
          if (rem_q > REM_WORD) per_q <= PER_W'(WORD_W);
          else                  per_q <= PER_W'(rem_q);
          state <= ST_XFER;
        end
        ST_XFER: begin
          if (byte_done) begin
            for (int b = 0; b < BYTES; b++) begin
              if (idx_q == IDX_W'(b)) acc_q[b*BYTE_W +: BYTE_W] <= byte_in;
            end
            word_q <= {{BYTE_W{1'b0}}, word_q[WORD_W-1:BYTE_W]};
            idx_q  <= idx_q + 1'b1;
            per_q  <= per_q - PER_BYTE;
            rem_q  <= rem_q - REM_BYTE;
            if (per_q <= PER_BYTE) state <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (rx_full) ovf_flag <= 1'b1;
          state <= ST_END;
        end
        ST_END: begin
          if (rem_nonpos && !multi) begin
            done_flag <= 1'b1;
            if (tx_empty) xch_flag <= 1'b0;
            state <= ST_IDLE;
          end else begin
            state <= ST_WORD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: request and data held until the shifter completes the byte
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_req && !byte_done) |=> (byte_req && $stable(byte_out)));
  // R9: every return to idle leaves the completion flag set
  assert_stop_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_flag);
  // R11: ending on an empty queue clears the exchange bit
  assert_empty_clears_xch_R11: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && tx_empty) |-> !xch_flag);
  // R10: completing a word into a full receive queue flags overflow
  assert_rx_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PUSH && rx_full) |=> ovf_flag);
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int NCH        = 4,
  parameter int SEL_W      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_burst_bits,
  input  logic [SEL_W-1:0]  cfg_chan_sel,
  input  logic [NCH-1:0]    cfg_chan_master,
  input  logic [NCH-1:0]    cfg_chan_wave,
  input  logic              cfg_start_mode,
  input  logic              xch_wr,
  input  logic              xch_wdata,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              rx_full,
  input  logic              clr_done,
  input  logic              clr_ovf,
  output logic              done_flag,
  output logic              ovf_flag,
  output logic              xch_flag,
  output logic              busy,
  output logic              byte_req,
  output logic [BYTE_W-1:0] byte_out,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [NCH-1:0]    cs_n
);
  logic              is_master, wave_sel, tx_accept;
  logic              tx_rd, rx_wr;
  logic [WORD_W-1:0] tx_rd_data, rx_wr_data;

  assign is_master = cfg_chan_master[cfg_chan_sel];
  assign wave_sel  = cfg_chan_wave[cfg_chan_sel];
  assign tx_accept = tx_push && !tx_full;

  spi_seq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .wr_en(tx_push), .wr_data(tx_data),
    .rd_en(tx_rd), .rd_data(tx_rd_data), .empty(tx_empty), .full(tx_full)
  );

  spi_seq_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr_en(rx_wr), .wr_data(rx_wr_data),
    .rd_en(rx_pop), .rd_data(rx_data), .empty(rx_empty), .full(rx_full)
  );

  spi_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .burst_field(cfg_burst_bits),
    .is_master(is_master), .wave_sel(wave_sel), .start_mode(cfg_start_mode),
    .tx_accept(tx_accept), .xch_wr(xch_wr), .xch_wdata(xch_wdata),
    .clr_done(clr_done), .clr_ovf(clr_ovf), .tx_empty(tx_empty),
    .tx_rd_data(tx_rd_data), .rx_full(rx_full), .byte_done(byte_done),
    .byte_in(byte_in), .tx_rd(tx_rd), .rx_wr(rx_wr), .rx_wr_data(rx_wr_data),
    .byte_req(byte_req), .byte_out(byte_out), .done_flag(done_flag),
    .ovf_flag(ovf_flag), .xch_flag(xch_flag), .busy(busy)
  );

  spi_seq_csdrv #(.NCH(NCH), .SEL_W(SEL_W)) u_cs (
    .clk(clk), .rst(rst), .is_master(is_master), .sel(cfg_chan_sel), .cs_n(cs_n)
  );
endmodule

// File: tb/sim_spi_xfer_seq.sv
module sim_spi_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] cfg_burst_bits;
  logic [1:0]  cfg_chan_sel;
  logic [3:0]  cfg_chan_master, cfg_chan_wave;
  logic        cfg_start_mode, xch_wr, xch_wdata, tx_push, rx_pop;
  logic [31:0] tx_data, rx_data;
  logic        tx_full, tx_empty, rx_empty, rx_full, clr_done, clr_ovf;
  logic        done_flag, ovf_flag, xch_flag, busy, byte_req, byte_done;
  logic [7:0]  byte_out, byte_in;
  logic [3:0]  cs_n;

  int total = 0;
  int fails = 0;
  logic [7:0]  exp_bytes[$];
  logic [31:0] exp_rx[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_seq u0 (
    .clk(clk), .rst(rst), .cfg_burst_bits(cfg_burst_bits), .cfg_chan_sel(cfg_chan_sel),
    .cfg_chan_master(cfg_chan_master), .cfg_chan_wave(cfg_chan_wave),
    .cfg_start_mode(cfg_start_mode), .xch_wr(xch_wr), .xch_wdata(xch_wdata),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full),
    .clr_done(clr_done), .clr_ovf(clr_ovf), .done_flag(done_flag), .ovf_flag(ovf_flag),
    .xch_flag(xch_flag), .busy(busy), .byte_req(byte_req), .byte_out(byte_out),
    .byte_done(byte_done), .byte_in(byte_in), .cs_n(cs_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Shifter model and byte monitor: compares each sent byte with the scoreboard
  int sh_cnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      byte_done <= 1'b0; byte_in <= '0; sh_cnt = 0;
    end else if (byte_done) begin
      byte_done <= 1'b0;
    end else if (byte_req) begin
      if (sh_cnt == 2) begin
        sh_cnt = 0;
        byte_done <= 1'b1;
        byte_in   <= byte_out ^ 8'hA5;
        if (exp_bytes.size() == 0) check("R2 unexpected byte", {24'h0, byte_out}, 32'hFFFF_FFFF);
        else check("R2 byte order", {24'h0, byte_out}, {24'h0, exp_bytes.pop_front()});
      end else begin
        sh_cnt++;
      end
    end
  end

  // Driver side of the scoreboard
  task automatic expect_word(input logic [31:0] d, input int nbytes, input bit keep);
    logic [31:0] r = '0;
    for (int i = 0; i < nbytes; i++) begin
      exp_bytes.push_back(d[i*8 +: 8]);
      r[i*8 +: 8] = d[i*8 +: 8] ^ 8'hA5;
    end
    if (keep) exp_rx.push_back(r);
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); tx_push = 1'b1; tx_data = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic write_xch(input logic v);
    @(negedge clk); xch_wr = 1'b1; xch_wdata = v;
    @(negedge clk); xch_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic read_rx(input string tag);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    if (exp_rx.size() == 0) check({tag, " no expected word"}, rx_data, 32'hx);
    else check(tag, rx_data, exp_rx.pop_front());
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_done = 1'b1; clr_ovf = 1'b1;
    @(negedge clk); clr_done = 1'b0; clr_ovf = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_burst_bits = 12'd31; cfg_chan_sel = 2'd1; cfg_chan_master = 4'b0000;
    cfg_chan_wave = 4'b0000; cfg_start_mode = 1'b0; xch_wr = 1'b0; xch_wdata = 1'b0;
    tx_push = 1'b0; tx_data = '0; rx_pop = 1'b0; clr_done = 1'b0; clr_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5 reset cs_n", {28'h0, cs_n}, 32'hF);
    check("R13 reset flags", {27'h0, tx_empty, rx_empty, done_flag, ovf_flag, busy}, 32'b11000);

    // R5 chip select decode
    cfg_chan_master = 4'b0010;
    repeat (2) @(negedge clk);
    check("R5 master ch1", {28'h0, cs_n}, 32'hD);
    cfg_chan_sel = 2'd2;
    repeat (2) @(negedge clk);
    check("R5 non-master ch2", {28'h0, cs_n}, 32'hF);
    cfg_chan_sel = 2'd1;

    // R6 R2 immediate-start 32-bit burst
    cfg_start_mode = 1'b1;
    expect_word(32'h4433_2211, 4, 1);
    push(32'h4433_2211);
    wait_idle();
    check("R11 done after empty", {31'h0, done_flag}, 32'h1);
    check("R11 xch cleared", {31'h0, xch_flag}, 32'h0);
    clear_flags();
    check("R13 done cleared", {31'h0, done_flag}, 32'h0);
    read_rx("R2 rx full word");

    // R12 push during a run is only queued; R6 mode rising edge drains it
    expect_word(32'h8877_6655, 4, 1);
    push(32'h8877_6655);
    push(32'hCCBB_AA99);
    wait_idle();
    check("R12 queued word not started", {31'h0, tx_empty}, 32'h0);
    expect_word(32'hCCBB_AA99, 4, 1);
    @(negedge clk); cfg_start_mode = 1'b0;
    @(negedge clk); cfg_start_mode = 1'b1;
    wait_idle();
    check("R6 rising mode drains", {31'h0, tx_empty}, 32'h1);
    read_rx("R12 rx first");
    read_rx("R6 rx second");

    // R7 R9 16-bit bursts with exchange bit
    cfg_start_mode = 1'b0; cfg_burst_bits = 12'd15; clear_flags();
    push(32'hDDCC_BBAA);
    push(32'h1357_9BDF);
    repeat (3) @(negedge clk);
    check("R7 push alone no start", {31'h0, busy}, 32'h0);
    expect_word(32'hDDCC_BBAA, 2, 1);
    write_xch(1'b1);
    wait_idle();
    check("R9 done set", {31'h0, done_flag}, 32'h1);
    check("R9 stops with words left", {31'h0, tx_empty}, 32'h0);
    check("R9 xch still held", {31'h0, xch_flag}, 32'h1);
    write_xch(1'b1);
    repeat (4) @(negedge clk);
    check("R7 held one no restart", {31'h0, tx_empty}, 32'h0);
    expect_word(32'h1357_9BDF, 2, 1);
    write_xch(1'b0);
    write_xch(1'b1);
    wait_idle();
    check("R11 empty after second", {30'h0, tx_empty, xch_flag}, 32'b10);
    read_rx("R2 rx upper zero");
    read_rx("R7 rx second burst");

    // R4 40-bit burst spans words; R1 12-bit rounds to 2 bytes
    cfg_burst_bits = 12'd39;
    push(32'h2468_ACE0); push(32'hF1E2_D3C4); push(32'h0BAD_F00D);
    expect_word(32'h2468_ACE0, 4, 1);
    expect_word(32'hF1E2_D3C4, 1, 1);
    write_xch(1'b1);
    wait_idle();
    check("R4 third word left", {31'h0, tx_empty}, 32'h0);
    read_rx("R4 first word");
    read_rx("R4 carried byte");
    cfg_burst_bits = 12'd11;
    expect_word(32'h0BAD_F00D, 2, 1);
    write_xch(1'b0); write_xch(1'b1);
    wait_idle();
    read_rx("R1 rounded burst");

    // R6 non-master never starts
    cfg_chan_master = 4'b0000; cfg_start_mode = 1'b1;
    push(32'h5A5A_1234);
    repeat (4) @(negedge clk);
    check("R6 non-master idle", {30'h0, busy, tx_empty}, 32'b00);
    check("R5 non-master cs", {28'h0, cs_n}, 32'hF);
    cfg_chan_master = 4'b0010;
    expect_word(32'h5A5A_1234, 2, 1);
    @(negedge clk); cfg_start_mode = 1'b0;
    @(negedge clk); cfg_start_mode = 1'b1;
    wait_idle();
    read_rx("R6 after master");

    // R10 receive overflow
    cfg_burst_bits = 12'd7; clear_flags();
    for (int i = 0; i < 9; i++) begin
      expect_word(32'h100 + i, 1, i < 8);
      push(32'h100 + i);
      wait_idle();
    end
    check("R10 ovf set", {30'h0, ovf_flag, rx_full}, 32'b11);
    clear_flags();
    check("R13 ovf cleared", {31'h0, ovf_flag}, 32'h0);
    for (int i = 0; i < 8; i++) read_rx("R10 kept words");
    check("R10 rx drained", {31'h0, rx_empty}, 32'h1);

    // R8 multi-burst with R13 full-queue drop
    cfg_start_mode = 1'b0; cfg_chan_wave = 4'b0010;
    for (int i = 0; i < 9; i++) begin
      if (i < 8) expect_word(32'hA0 + i, 1, 1);
      push(32'hA0 + i);
    end
    check("R13 tx full", {31'h0, tx_full}, 32'h1);
    write_xch(1'b1);
    repeat (20) @(negedge clk);
    check("R8 busy and xch held mid-run", {30'h0, busy, xch_flag}, 32'b11);
    wait_idle();
    check("R8 all words sent", {29'h0, tx_empty, xch_flag, done_flag}, 32'b101);
    for (int i = 0; i < 8; i++) read_rx("R8 multi word");
    check("R13 dropped push absent", {31'h0, rx_empty}, 32'h1);
    check("R2 all expected bytes sent", exp_bytes.size(), 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule